// File: doc/BRIEF.md
# Two-Wire Secure Memory Command Front End

This block is the slave side of a two-wire serial link in front of a zoned secure memory. It samples the serial clock and data lines in a fast system-clock domain and detects start and stop conditions. It shifts command, address and data bytes in most significant bit first and acknowledges them by pulling the open-drain data line low. It decodes a family of eight command codes and holds the user-zone selection. It also generates byte addresses: sequential reads wrap inside a zone and page writes wrap inside 16 bytes.

The memory array, the access-rights policy and the password and authentication logic are outside the block. The block reaches them through a request port that carries a command code, an 11-bit address and a data byte. For a read request, the memory answers with a grant flag and read data in the same system cycle. When a write-type transaction ends, a commit pulse starts a nonvolatile cycle whose length is a parameter. While that cycle runs, the block refuses every command, so the host can poll for completion. When the card reset input rises, the block clears all privileges and shifts out a 32-bit answer-to-reset word.

Top module: `secmem_2w_front`

## Requirements
- R1: The block acknowledges a command byte only if its upper five bits are 10110. Any other first byte is NACKed and ends the transaction, and no request is issued.
- R2: Command code 2 (byte B2h) takes the low three bits of its next byte as the zone number. That zone drives `mem_addr_o[10:8]` for every user-zone request until the next B2h.
- R3: After reset, user-zone commands B0h and B1h are NACKed and issue no request until a B2h has been received.
- R4: A user read (B1h) takes one address byte and then returns data bytes. The address advances by one after each byte the host ACKs and wraps from FFh to 00h inside the same zone. A host NACK ends the read and releases SDA.
- R5: For a user write (B0h) or configuration write (B4h), the byte after the command is the address. Each later data byte issues a write request, and only address bits [3:0] then increment, so the address wraps inside a 16-byte page.
- R6: If the memory withholds the grant on a read request, the byte sent to the host is 00h.
- R7: A stop that ends a transaction whose command was ACKed with code 0, 3, 4, 6 or 7 gives a one-cycle `mem_commit_o` pulse. `busy_o` is then high for exactly WR_TICKS system cycles. Code 2 starts no write cycle.
- R8: While `busy_o` is high, every command byte is NACKed and no request is issued. Once `busy_o` is low again, a valid command is ACKed.
- R9: A configuration read (B5h) at address 80h returns the single byte {00000b, fuses_i}, issues no memory request, and then releases SDA even if the host ACKs.
- R10: A rising card reset gives one `priv_clr_o` pulse and drives ATR_WORD on SDA least significant bit first. Bit 0 appears at once, bit k appears after the k-th SCL fall, and SDA is released after the 32nd fall.
- R11: For codes 3, 6 and 7, each byte after the command issues a write request. The request carries the command code, the byte's index (0 for the first byte) as address, and the byte as data.
- R12: The block changes its drive of SDA only while SCL is low. Read data goes out MSB first, and the ACK is driven low for the whole ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from host (asynchronous) |
| sda_i | input | 1 | Resolved serial data line (asynchronous) |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| card_rst_i | input | 1 | Card reset line (asynchronous) |
| fuses_i | input | 3 | Lifecycle fuse levels for the fuse read |
| mem_req_o | output | 1 | One-cycle memory request strobe |
| mem_we_o | output | 1 | Request is a write |
| mem_cmd_o | output | 3 | Command code of the request |
| mem_addr_o | output | 11 | Request address (zone in [10:8] for user zone) |
| mem_wdata_o | output | 8 | Write data byte |
| mem_gnt_i | input | 1 | Read permitted, valid while mem_req_o is high |
| mem_rdata_i | input | 8 | Read data, valid while mem_req_o is high |
| mem_commit_o | output | 1 | One-cycle pulse that starts the nonvolatile cycle |
| busy_o | output | 1 | Nonvolatile cycle in progress |
| priv_clr_o | output | 1 | One-cycle pulse that clears privileges on card reset |

## Verification
The assertions assume that the host changes SDA only while SCL is low, except for start and stop conditions. They also assume that SCL is low when the card reset rises. Each SCL phase is assumed to last well beyond the three-flop synchroniser delay, so the block's drive always moves inside the low phase. The host tasks in the bench hold every quarter of an SCL period for eight system clocks. They change the host's SDA level only in the quarter after SCL falls and raise the card reset only between transactions, with SCL low.

// File: rtl/secmem_2w_front.sv
module secmem_2w_front #(
  parameter int          WR_TICKS = 2000,
  parameter logic [31:0] ATR_WORD = 32'h3B96_C05A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic        card_rst_i,
  input  logic [2:0]  fuses_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [2:0]  mem_cmd_o,
  output logic [10:0] mem_addr_o,
  output logic [7:0]  mem_wdata_o,
  input  logic        mem_gnt_i,
  input  logic [7:0]  mem_rdata_i,
  output logic        mem_commit_o,
  output logic        busy_o,
  output logic        priv_clr_o
);

  localparam int CW = $clog2(WR_TICKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK} st_t;

  logic [2:0] scl_q, sda_q, crst_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q  <= 3'b000;
      sda_q  <= 3'b111;
      crst_q <= 3'b000;
    end else begin
      scl_q  <= {scl_q[1:0], scl_i};
      sda_q  <= {sda_q[1:0], sda_i};
      crst_q <= {crst_q[1:0], card_rst_i};
    end

  logic scl_s, sda_s, crst_s;
  assign scl_s  = scl_q[1];
  assign sda_s  = sda_q[1];
  assign crst_s = crst_q[1];

  logic scl_rise, scl_fall, start_c, stop_c, crst_rise;
  assign scl_rise  = scl_s & ~scl_q[2];
  assign scl_fall  = ~scl_s & scl_q[2];
  assign start_c   = scl_s & scl_q[2] & sda_q[2] & ~sda_s;
  assign stop_c    = scl_s & scl_q[2] & ~sda_q[2] & sda_s;
  assign crst_rise = crst_s & ~crst_q[2];

  st_t        st;
  logic [2:0] bitcnt;
  logic [6:0] sh;
  logic [3:0] nbyte;
  logic [2:0] cmd;
  logic [7:0] addr;
  logic [2:0] zone;
  logic       zone_ok;
  logic       ackit, ph, go_tx, drive_ack;
  logic       wr_pend, fuse_only, host_ack;
  logic [7:0] tx_sh;
  logic [CW-1:0] busy_cnt;
  logic       atr_on;
  logic [4:0] aidx;

  logic [7:0] byte_in;
  logic       cmd_ok, cmd_wr;
  assign byte_in = {sh, sda_s};
  assign cmd_ok  = (byte_in[7:3] == 5'b10110) && (busy_cnt == '0) &&
                   (zone_ok || (byte_in[2:1] != 2'b00));
  assign cmd_wr  = (byte_in[2:0] == 3'd0) || (byte_in[2:0] == 3'd3) ||
                   (byte_in[2:0] == 3'd4) || (byte_in[2:0] == 3'd6) ||
                   (byte_in[2:0] == 3'd7);

  assign busy_o   = (busy_cnt != '0);
  assign sda_oe_o = drive_ack | ((st == S_TX) & ~tx_sh[7]) | (atr_on & ~ATR_WORD[aidx]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;       bitcnt <= '0;     sh <= '0;        nbyte <= '0;
      cmd <= '0;          addr <= '0;       zone <= '0;      zone_ok <= 1'b0;
      ackit <= 1'b0;      ph <= 1'b0;       go_tx <= 1'b0;   drive_ack <= 1'b0;
      wr_pend <= 1'b0;    fuse_only <= 1'b0; host_ack <= 1'b0; tx_sh <= 8'hFF;
      busy_cnt <= '0;     atr_on <= 1'b0;   aidx <= '0;
      mem_req_o <= 1'b0;  mem_we_o <= 1'b0; mem_cmd_o <= '0; mem_addr_o <= '0;
      mem_wdata_o <= '0;  mem_commit_o <= 1'b0; priv_clr_o <= 1'b0;
    end else begin
      mem_req_o    <= 1'b0;
      mem_commit_o <= 1'b0;
      priv_clr_o   <= 1'b0;
      if (busy_cnt != '0) busy_cnt <= busy_cnt - CW'(1);
      if (mem_req_o && !mem_we_o) tx_sh <= mem_gnt_i ? mem_rdata_i : 8'h00;
      if (atr_on && scl_fall) begin
        if (aidx == 5'd31) atr_on <= 1'b0;
        else aidx <= aidx + 5'd1;
      end

      if (crst_rise) begin
        st <= S_IDLE; atr_on <= 1'b1; aidx <= '0; priv_clr_o <= 1'b1;
        drive_ack <= 1'b0; wr_pend <= 1'b0;
      end else if (start_c && !crst_s) begin
        st <= S_RX; bitcnt <= '0; nbyte <= '0; drive_ack <= 1'b0;
        wr_pend <= 1'b0; atr_on <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; drive_ack <= 1'b0;
        if (wr_pend) begin
          mem_commit_o <= 1'b1;
          busy_cnt     <= CW'(WR_TICKS);
          wr_pend      <= 1'b0;
        end
      end else begin
        case (st)
          S_RX: if (scl_rise) begin
            if (bitcnt != 3'd7) begin
              sh     <= {sh[5:0], sda_s};
              bitcnt <= bitcnt + 3'd1;
            end else begin
              st <= S_RXACK; ph <= 1'b0; go_tx <= 1'b0;
              if (nbyte != 4'hF) nbyte <= nbyte + 4'd1;
              if (nbyte == 4'd0) begin
                ackit   <= cmd_ok;
                cmd     <= byte_in[2:0];
                wr_pend <= cmd_ok && cmd_wr;
              end else begin
                case (cmd)
                  3'd0, 3'd4: begin
                    ackit <= 1'b1;
                    if (nbyte == 4'd1) addr <= byte_in;
                    else begin
                      mem_req_o   <= 1'b1;
                      mem_we_o    <= 1'b1;
                      mem_cmd_o   <= cmd;
                      mem_addr_o  <= (cmd == 3'd0) ? {zone, addr} : {3'b000, addr};
                      mem_wdata_o <= byte_in;
                      addr[3:0]   <= addr[3:0] + 4'd1;
                    end
                  end
                  3'd1, 3'd5: begin
                    ackit <= 1'b1;
                    addr  <= byte_in;
                    go_tx <= 1'b1;
                  end
                  3'd2: begin
                    ackit <= (nbyte == 4'd1);
                    if (nbyte == 4'd1) begin
                      zone    <= byte_in[2:0];
                      zone_ok <= 1'b1;
                    end
                  end
                  default: begin
                    ackit       <= 1'b1;
                    mem_req_o   <= 1'b1;
                    mem_we_o    <= 1'b1;
                    mem_cmd_o   <= cmd;
                    mem_addr_o  <= {7'b0, 4'(nbyte - 4'd1)};
                    mem_wdata_o <= byte_in;
                  end
                endcase
              end
            end
          end
          S_RXACK: if (scl_fall) begin
            if (!ph) begin
              ph        <= 1'b1;
              drive_ack <= ackit;
              if (ackit && go_tx) begin
                if (cmd == 3'd5 && addr == 8'h80) begin
                  tx_sh     <= {5'b00000, fuses_i};
                  fuse_only <= 1'b1;
                end else begin
                  fuse_only  <= 1'b0;
                  mem_req_o  <= 1'b1;
                  mem_we_o   <= 1'b0;
                  mem_cmd_o  <= cmd;
                  mem_addr_o <= (cmd == 3'd1) ? {zone, addr} : {3'b000, addr};
                end
              end
            end else begin
              drive_ack <= 1'b0;
              bitcnt    <= '0;
              if (!ackit)     st <= S_IDLE;
              else if (go_tx) st <= S_TX;
              else            st <= S_RX;
            end
          end
          S_TX: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              st   <= S_TXACK;
              addr <= (cmd == 3'd5) ? {addr[7], addr[6:0] + 7'd1} : addr + 8'd1;
            end else begin
              tx_sh  <= {tx_sh[6:0], 1'b1};
              bitcnt <= bitcnt + 3'd1;
            end
          end
          S_TXACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_s;
              if (!sda_s && !fuse_only) begin
                mem_req_o  <= 1'b1;
                mem_we_o   <= 1'b0;
                mem_cmd_o  <= cmd;
                mem_addr_o <= (cmd == 3'd1) ? {zone, addr} : {3'b000, addr};
              end
            end
            if (scl_fall) begin
              bitcnt <= '0;
              st     <= (host_ack && !fuse_only) ? S_TX : S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end

  AST_ACK_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    drive_ack |-> (st == S_RXACK)); // R1

  AST_USER_NEEDS_ZONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_cmd_o[2:1] == 2'b00) |-> zone_ok); // R3

  AST_COMMIT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_commit_o |-> busy_o); // R7

  AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !mem_req_o); // R8

  AST_PRIV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    priv_clr_o |=> !priv_clr_o); // R10

  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s); // R12

endmodule

// File: tb/tb_secmem_2w_front.sv
module tb_secmem_2w_front;
  localparam int          WR   = 1000;
  localparam logic [31:0] ATRV = 32'h3B96_C05A;
  localparam int          Q    = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b0, host_low = 1'b0, card_rst = 1'b0;
  logic [2:0] fuses = 3'b101;
  logic sda_oe, mem_req, mem_we, mem_gnt, mem_commit, busy, priv_clr;
  logic [2:0] mem_cmd;
  logic [10:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  wire sda_line = ~(host_low | sda_oe);

  always #4 clk = ~clk;

  assign mem_rdata = mem_addr[7:0] ^ {mem_addr[10:8], 5'b10101};
  assign mem_gnt   = (mem_addr[7:0] != 8'h44);

  secmem_2w_front #(.WR_TICKS(WR), .ATR_WORD(ATRV)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .card_rst_i(card_rst), .fuses_i(fuses),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_cmd_o(mem_cmd), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata),
    .mem_commit_o(mem_commit), .busy_o(busy), .priv_clr_o(priv_clr));

  int checks = 0, errors = 0, nlog = 0, ncommit = 0, npriv = 0, blen = 0;
  logic [10:0] lg_addr [64];
  logic [7:0]  lg_data [64];
  logic        lg_we   [64];
  logic [2:0]  lg_cmd  [64];
  logic done = 1'b0;

  always @(posedge clk) begin
    if (rst_n && mem_req && nlog < 64) begin
      lg_addr[nlog] <= mem_addr; lg_data[nlog] <= mem_wdata;
      lg_we[nlog] <= mem_we; lg_cmd[nlog] <= mem_cmd;
      nlog <= nlog + 1;
    end
    if (mem_commit) ncommit <= ncommit + 1;
    if (priv_clr) npriv <= npriv + 1;
    if (mem_commit) blen <= 1;
    else if (busy) blen <= blen + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    host_low = 1'b0; wq(Q); scl = 1'b1; wq(Q); host_low = 1'b1; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    host_low = 1'b1; wq(Q); scl = 1'b1; wq(Q); host_low = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic send_bit(input logic b);
    host_low = ~b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
  endtask

  task automatic read_bit(output logic b);
    host_low = 1'b0; wq(Q); scl = 1'b1; wq(Q); b = sda_line; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    read_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic hack);
    for (int i = 7; i >= 0; i--) read_bit(v[i]);
    send_bit(~hack);
  endtask

  function automatic logic [7:0] model(input logic [2:0] z, input logic [7:0] a);
    return a ^ {z, 5'b10101};
  endfunction

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) wq(1);
    wq(4);
  endtask

  task automatic t_reset();
    chk("R12 reset sda released", sda_oe, 1'b0);
    chk("R8 reset busy low", busy, 1'b0);
    chk("R7 reset no commit", ncommit, 0);
  endtask

  task automatic t_zone_lock();
    logic a; int n0 = nlog;
    bus_start(); send_byte(8'hB1, a); bus_stop();
    chk("R3 user read before zone NACK", a, 1'b0);
    bus_start(); send_byte(8'hB0, a); bus_stop();
    chk("R3 user write before zone NACK", a, 1'b0);
    chk("R3 no request before zone", nlog - n0, 0);
  endtask

  task automatic t_bad_cmd();
    logic a; int n0 = nlog;
    bus_start(); send_byte(8'hA1, a); bus_stop();
    chk("R1 bad command A1 NACK", a, 1'b0);
    bus_start(); send_byte(8'h35, a); bus_stop();
    chk("R1 bad command 35 NACK", a, 1'b0);
    bus_start(); send_byte(8'hB5, a); bus_stop();
    chk("R1 config read command ACK", a, 1'b1);
    chk("R1 no request from rejected bytes", nlog - n0, 0);
  endtask

  task automatic set_zone(input logic [2:0] z);
    logic a1, a2;
    bus_start(); send_byte(8'hB2, a1); send_byte({5'b0, z}, a2); bus_stop();
    chk("R2 zone command ACK", a1, 1'b1);
    chk("R2 zone byte ACK", a2, 1'b1);
    chk("R7 zone command no busy", busy, 1'b0);
  endtask

  task automatic t_seq_read();
    logic a1, a2; logic [7:0] d0, d1, d2; int n0 = nlog;
    bus_start(); send_byte(8'hB1, a1); send_byte(8'hFE, a2);
    chk("R3 user read ACK after zone", a1, 1'b1);
    chk("R4 read address ACK", a2, 1'b1);
    recv_byte(d0, 1'b1); recv_byte(d1, 1'b1); recv_byte(d2, 1'b0);
    chk("R4 first byte", d0, model(3'd5, 8'hFE));
    chk("R4 second byte", d1, model(3'd5, 8'hFF));
    chk("R4 wrap byte", d2, model(3'd5, 8'h00));
    wq(Q);
    chk("R4 SDA released after NACK", sda_oe, 1'b0);
    bus_stop();
    chk("R4 three fetches", nlog - n0, 3);
    chk("R2 fetch addr 0", lg_addr[n0], {3'd5, 8'hFE});
    chk("R4 fetch addr 2", lg_addr[n0 + 2], {3'd5, 8'h00});
  endtask

  task automatic t_denied();
    logic a1, a2; logic [7:0] d0, d1;
    bus_start(); send_byte(8'hB1, a1); send_byte(8'h43, a2);
    recv_byte(d0, 1'b1); recv_byte(d1, 1'b0); bus_stop();
    chk("R6 permitted byte", d0, model(3'd5, 8'h43));
    chk("R6 denied byte is zero", d1, 8'h00);
  endtask

  task automatic t_page_write();
    logic a; logic [7:0] dat [4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    logic [7:0] ofs [4] = '{8'h1E, 8'h1F, 8'h10, 8'h11};
    int n0 = nlog, c0 = ncommit;
    bus_start(); send_byte(8'hB0, a); send_byte(8'h1E, a);
    for (int i = 0; i < 4; i++) send_byte(dat[i], a);
    chk("R5 data byte ACK", a, 1'b1);
    chk("R7 no commit before stop", ncommit - c0, 0);
    bus_stop();
    chk("R5 four write requests", nlog - n0, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R5 page address", lg_addr[n0 + i], {3'd5, ofs[i]});
      chk("R5 write data", {lg_we[n0 + i], lg_data[n0 + i]}, {1'b1, dat[i]});
    end
    chk("R7 commit on stop", ncommit - c0, 1);
    chk("R7 busy after stop", busy, 1'b1);
  endtask

  task automatic t_busy();
    logic a; int n0 = nlog;
    bus_start(); send_byte(8'hB1, a); bus_stop();
    chk("R8 command NACK while busy", a, 1'b0);
    chk("R8 no request while busy", nlog - n0, 0);
    wait_idle();
    chk("R7 busy length", blen, WR);
    bus_start(); send_byte(8'hB1, a); bus_stop();
    chk("R8 command ACK after cycle", a, 1'b1);
  endtask

  task automatic t_fuses();
    logic a1, a2; logic [7:0] d0, d1; int n0 = nlog;
    bus_start(); send_byte(8'hB5, a1); send_byte(8'h80, a2);
    recv_byte(d0, 1'b1);
    for (int i = 7; i >= 0; i--) read_bit(d1[i]);
    bus_stop();
    chk("R9 fuse byte", d0, {5'b0, fuses});
    chk("R9 released after fuse byte", d1, 8'hFF);
    chk("R9 no memory request", nlog - n0, 0);
  endtask

  task automatic t_ctrl();
    logic a; logic [7:0] dat [4] = '{8'h0A, 8'h11, 8'h22, 8'h33};
    int n0 = nlog, c0 = ncommit;
    bus_start(); send_byte(8'hB3, a);
    for (int i = 0; i < 4; i++) send_byte(dat[i], a);
    bus_stop();
    chk("R11 four forwarded bytes", nlog - n0, 4);
    for (int i = 0; i < 4; i++)
      chk("R11 index cmd data", {lg_cmd[n0 + i], lg_addr[n0 + i], lg_data[n0 + i]},
          {3'd3, 11'(i), dat[i]});
    chk("R7 verify command commits", ncommit - c0, 1);
    wait_idle();
  endtask

  task automatic t_atr();
    logic [31:0] w; logic b; int p0 = npriv;
    card_rst = 1'b1; wq(2*Q); card_rst = 1'b0; wq(Q);
    for (int i = 0; i < 32; i++) read_bit(w[i]);
    read_bit(b);
    chk("R10 answer word LSB first", w, ATRV);
    chk("R10 released after 32 pulses", b, 1'b1);
    chk("R10 one privilege clear", npriv - p0, 1);
  endtask

  task automatic t_zone_change();
    logic a; logic [7:0] d;
    set_zone(3'd2);
    bus_start(); send_byte(8'hB1, a); send_byte(8'h10, a); recv_byte(d, 1'b0); bus_stop();
    chk("R2 new zone data", d, model(3'd2, 8'h10));
    chk("R2 new zone address", lg_addr[nlog - 1], {3'd2, 8'h10});
  endtask

  initial begin
    wq(5); rst_n = 1'b1; wq(10);
    t_reset();
    t_zone_lock();
    t_bad_cmd();
    set_zone(3'd5);
    t_seq_read();
    t_denied();
    t_page_write();
    t_busy();
    t_fuses();
    t_ctrl();
    t_atr();
    t_zone_change();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule